// File: doc/BRIEF.md
# Storage Controller Register Window

This block decodes a 4 KiB memory-mapped window for a two-drive storage controller. Each register occupies its own 16-byte slot, so the register index is the byte address with its low four bits dropped. A request carries an access size of one, two or four bytes, and each register accepts only the sizes listed below. Accesses to the data port, the task-file registers and the alternate-status/device-control register are forwarded to the drive logic over strobed side ports. The timing register and the interrupt state register are held inside this block.

The interrupt state register combines two interrupt lines. One is a DMA-completion bit that software clears by writing a one to it. The other is a live image of the disk interrupt. Both lines are also passed unchanged to their own outputs. Little-endian lane order applies: narrow data always sits in the low bits of the 32-bit bus. The block accepts a request on every cycle and answers each one with a response on the following cycle.

Top module: `stor_regwin`

## Requirements
- R1: The register index is `req_addr >> 4`; the low nibble of the address is ignored. A read of an index that has no register, or a read with a size the register does not accept, returns 0xFFFFFFFF. Size code 3 is illegal everywhere.
- R2: `req_ready` is always high. Every request with `req_valid` high produces `rsp_valid` high on the next cycle, and an idle cycle produces `rsp_valid` low on the next cycle. For a read, `rsp_rdata` carries the read value. For a write, `rsp_rdata` is 0xFFFFFFFF. Size codes are: 0 = one byte, 1 = two bytes, 2 = four bytes.
- R3: Index 0 (data port) accepts reads of any legal size and pulses `df_rd` in the request cycle. A one-byte read returns `df_rdata[7:0]` and a two-byte read returns `df_rdata[15:0]`, both zero-extended. A four-byte read returns all 32 bits. `df_wide` is high only for four-byte accesses.
- R4: Data-port writes are accepted only at two or four bytes; they pulse `df_wr` with `df_wdata = req_wdata`. A one-byte write to index 0 produces no strobe.
- R5: Indices 1 to 7 (task file) accept one-byte accesses only. Reads pulse `tf_rd`, writes pulse `tf_wr`, and `tf_idx` carries the index. Read data is `tf_rdata` zero-extended.
- R6: Indices 0x08 and 0x16 accept one-byte accesses only. A read pulses `alt_rd` and returns `alt_status`. A write pulses `ctl_wr` with `ctl_wdata = req_wdata[7:0]`.
- R7: Index 0x20 holds a 32-bit timing register. It is read and written only with four-byte accesses; writes of any other size leave it unchanged.
- R8: Index 0x30 is the interrupt state register and accepts four-byte reads only. Bit 31 is the DMA interrupt flag, bit 30 is the disk interrupt flag, and all other bits read as zero.
- R9: A rising edge on interrupt input n (0 = DMA, 1 = disk) sets bit 31−n in the next cycle, and a falling edge clears it in the next cycle.
- R10: A four-byte write to index 0x30 whose bit 31 is set clears bit 31. No write changes bit 30. A DMA rising edge in the same cycle wins over the clear.
- R11: `irq_dma_out` follows `irq_dma_in` and `irq_disk_out` follows `irq_disk_in` combinationally.
- R12: Reset clears the timing register and both interrupt flags. At most one side-port strobe is high in any cycle, and writes to unmapped indices or with illegal sizes change no state and pulse no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address in the window |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write data, low-lane aligned |
| rsp_valid | output | 1 | Response present, one cycle after request |
| rsp_rdata | output | 32 | Response data |
| df_rd | output | 1 | Data-port read strobe |
| df_wr | output | 1 | Data-port write strobe |
| df_wide | output | 1 | Data-port access is 32 bits |
| df_wdata | output | 32 | Data-port write value |
| df_rdata | input | 32 | Data-port read value |
| tf_rd | output | 1 | Task-file read strobe |
| tf_wr | output | 1 | Task-file write strobe |
| tf_idx | output | 3 | Task-file register number |
| tf_wdata | output | 8 | Task-file write value |
| tf_rdata | input | 8 | Task-file read value |
| alt_rd | output | 1 | Alternate-status read strobe |
| alt_status | input | 8 | Alternate-status value |
| ctl_wr | output | 1 | Device-control write strobe |
| ctl_wdata | output | 8 | Device-control write value |
| irq_dma_in | input | 1 | DMA interrupt input |
| irq_disk_in | input | 1 | Disk interrupt input |
| irq_dma_out | output | 1 | DMA interrupt output |
| irq_disk_out | output | 1 | Disk interrupt output |

## Verification
The hardest case is the one where a clearing write to the interrupt register lands in the same cycle as a new DMA rising edge. This case decides whether a fresh completion is lost. The stimulus first drops the DMA line, then raises it in exactly the cycle that carries the clear, and reads the register back on the next step to confirm that bit 31 survived. A related sequence clears bit 31 while the DMA line is still held high. It then shows that the bit stays clear until the line falls and rises again, while the disk image in bit 30 does not move.

// File: rtl/stor_regwin_pkg.sv
package stor_regwin_pkg;

  localparam logic [1:0] SZ_B1  = 2'd0;
  localparam logic [1:0] SZ_B2  = 2'd1;
  localparam logic [1:0] SZ_B4  = 2'd2;
  localparam logic [1:0] SZ_BAD = 2'd3;

  typedef enum logic [2:0] {
    RG_NONE, RG_DATA, RG_TASK, RG_STAT, RG_TIME, RG_IRQ
  } region_e;

  localparam int unsigned IX_DATA   = 0;
  localparam int unsigned IX_TASK_HI = 7;
  localparam int unsigned IX_STAT_A = 8;
  localparam int unsigned IX_STAT_B = 22;
  localparam int unsigned IX_TIME   = 32;
  localparam int unsigned IX_IRQ    = 48;

  function automatic region_e idx_region(input int unsigned idx);
    if (idx == IX_DATA)                             return RG_DATA;
    else if (idx <= IX_TASK_HI)                     return RG_TASK;
    else if (idx == IX_STAT_A || idx == IX_STAT_B)  return RG_STAT;
    else if (idx == IX_TIME)                        return RG_TIME;
    else if (idx == IX_IRQ)                         return RG_IRQ;
    else                                            return RG_NONE;
  endfunction

  function automatic logic size_legal(input region_e r, input logic [1:0] sz,
                                      input logic wr);
    case (r)
      RG_DATA: return wr ? (sz == SZ_B2 || sz == SZ_B4) : (sz != SZ_BAD);
      RG_TASK, RG_STAT: return sz == SZ_B1;
      RG_TIME: return sz == SZ_B4;
      RG_IRQ:  return sz == SZ_B4;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] fit_lanes(input logic [1:0] sz, input logic [31:0] w);
    case (sz)
      SZ_B1:   return {24'd0, w[7:0]};
      SZ_B2:   return {16'd0, w[15:0]};
      default: return w;
    endcase
  endfunction

endpackage

// File: rtl/stor_addr_dec.sv
module stor_addr_dec
  import stor_regwin_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned STRIDE_LG = 4
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output region_e           region,
  output logic              acc_ok,
  output logic [ADDR_W-STRIDE_LG-1:0] idx
);
  localparam int unsigned IDX_W = ADDR_W - STRIDE_LG;

  logic unused_low_nibble;
  assign unused_low_nibble = ^addr[STRIDE_LG-1:0];

  assign idx    = addr[ADDR_W-1:STRIDE_LG];
  assign region = idx_region(32'(idx));
  assign acc_ok = valid && (region != RG_NONE) && size_legal(region, size, write);

  initial begin
    if (IDX_W < 6) $error("window too small for register map");
  end
endmodule

// File: rtl/stor_irq_latch.sv
module stor_irq_latch #(
  parameter int unsigned NSRC = 2,
  parameter int unsigned DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic            clr_top,
  output logic [DW-1:0]   state
);
  logic [NSRC-1:0] flag;

  for (genvar n = 0; n < NSRC; n++) begin : g_src
    localparam bit CLR_ABLE = (n == 0);
    logic prev_q, bit_q;
    logic rise_w, fall_w;

    assign rise_w = irq_in[n] & ~prev_q;
    assign fall_w = ~irq_in[n] & prev_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        bit_q  <= 1'b0;
      end else begin
        prev_q <= irq_in[n];
        if (rise_w)                   bit_q <= 1'b1;
        else if (fall_w)              bit_q <= 1'b0;
        else if (CLR_ABLE && clr_top) bit_q <= 1'b0;
      end
    end

    assign flag[n] = bit_q;

    // R9
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_in[n]) |=> flag[n]);
    // R9
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_in[n]) |=> !flag[n]);
    if (CLR_ABLE) begin : g_w1c
      // R10
      irq_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_top && !irq_in[n]) |=> !flag[n]);
    end else begin : g_keep
      // R10
      irq_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_in[n] == $past(irq_in[n])) |=> $stable(flag[n]));
    end
  end

  always_comb begin
    state = '0;
    for (int n = 0; n < NSRC; n++) state[DW-1-n] = flag[n];
  end
endmodule

// File: rtl/stor_rsp_stage.sv
module stor_rsp_stage #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [DW-1:0] data_in,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '1;
    end else begin
      rsp_valid <= take;
      if (take) rsp_rdata <= data_in;
    end
  end
endmodule

// File: rtl/stor_regwin.sv
module stor_regwin
  import stor_regwin_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned STRIDE_LG = 4,
  parameter logic [31:0] TIME_RST  = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              df_rd,
  output logic              df_wr,
  output logic              df_wide,
  output logic [31:0]       df_wdata,
  input  logic [31:0]       df_rdata,
  output logic              tf_rd,
  output logic              tf_wr,
  output logic [2:0]        tf_idx,
  output logic [7:0]        tf_wdata,
  input  logic [7:0]        tf_rdata,
  output logic              alt_rd,
  input  logic [7:0]        alt_status,
  output logic              ctl_wr,
  output logic [7:0]        ctl_wdata,
  input  logic              irq_dma_in,
  input  logic              irq_disk_in,
  output logic              irq_dma_out,
  output logic              irq_disk_out
);
  localparam int unsigned IDX_W = ADDR_W - STRIDE_LG;
  localparam int unsigned NSRC  = 2;

  region_e          region;
  logic             acc_ok;
  logic [IDX_W-1:0] idx;
  logic             rd_hit, wr_hit;
  logic             tim_we, irq_clr;
  logic [31:0]      tim_q, irq_state, rd_word;
  logic [NSRC-1:0]  irq_vec;

  assign req_ready = 1'b1;

  stor_addr_dec #(.ADDR_W(ADDR_W), .STRIDE_LG(STRIDE_LG)) u_dec (
    .valid(req_valid), .write(req_write), .addr(req_addr), .size(req_size),
    .region(region), .acc_ok(acc_ok), .idx(idx)
  );

  assign rd_hit = acc_ok && !req_write;
  assign wr_hit = acc_ok &&  req_write;

  // side-port strobes
  assign df_rd    = rd_hit && region == RG_DATA;
  assign df_wr    = wr_hit && region == RG_DATA;
  assign df_wide  = req_size == SZ_B4;
  assign df_wdata = req_wdata;
  assign tf_rd    = rd_hit && region == RG_TASK;
  assign tf_wr    = wr_hit && region == RG_TASK;
  assign tf_idx   = idx[2:0];
  assign tf_wdata = req_wdata[7:0];
  assign alt_rd   = rd_hit && region == RG_STAT;
  assign ctl_wr   = wr_hit && region == RG_STAT;
  assign ctl_wdata = req_wdata[7:0];

  // timing register
  assign tim_we = wr_hit && region == RG_TIME;
  always_ff @(posedge clk) begin
    if (!rst_n)      tim_q <= TIME_RST;
    else if (tim_we) tim_q <= req_wdata;
  end

  // interrupt register
  assign irq_vec = {irq_disk_in, irq_dma_in};
  assign irq_clr = wr_hit && region == RG_IRQ && req_wdata[31];

  stor_irq_latch #(.NSRC(NSRC), .DW(32)) u_irq (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_vec), .clr_top(irq_clr), .state(irq_state)
  );

  assign irq_dma_out  = irq_dma_in;
  assign irq_disk_out = irq_disk_in;

  // read mux
  always_comb begin
    rd_word = '1;
    if (rd_hit) begin
      case (region)
        RG_DATA: rd_word = fit_lanes(req_size, df_rdata);
        RG_TASK: rd_word = {24'd0, tf_rdata};
        RG_STAT: rd_word = {24'd0, alt_status};
        RG_TIME: rd_word = tim_q;
        RG_IRQ:  rd_word = irq_state;
        default: rd_word = '1;
      endcase
    end
  end

  stor_rsp_stage #(.DW(32)) u_rsp (
    .clk(clk), .rst_n(rst_n), .take(req_valid && req_ready), .data_in(rd_word),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  // R2
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R12
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({df_rd, df_wr, tf_rd, tf_wr, alt_rd, ctl_wr}));
  // R7
  timing_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && req_size == SZ_B4) |=> $stable(tim_q));
  // R1
  bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == SZ_BAD) |=> rsp_rdata == 32'hFFFF_FFFF);
  // R8
  irq_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_state[29:0] == 30'd0);
endmodule

// File: tb/stor_regwin_test.sv
`timescale 1ns/1ps
module stor_regwin_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        df_rd, df_wr, df_wide;
  logic [31:0] df_wdata;
  logic [31:0] df_rdata = 32'h1234_ABCD;
  logic        tf_rd, tf_wr;
  logic [2:0]  tf_idx;
  logic [7:0]  tf_wdata;
  logic [7:0]  tf_rdata = 8'h5A;
  logic        alt_rd;
  logic [7:0]  alt_status = 8'h50;
  logic        ctl_wr;
  logic [7:0]  ctl_wdata;
  logic        irq_dma_in = 1'b0, irq_disk_in = 1'b0;
  logic        irq_dma_out, irq_disk_out;

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model state
  int unsigned m_tim = 0;
  bit m_b31 = 0, m_b30 = 0, m_p0 = 0, m_p1 = 0;

  always #4 clk = ~clk;

  stor_regwin uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .df_rd(df_rd), .df_wr(df_wr), .df_wide(df_wide), .df_wdata(df_wdata),
    .df_rdata(df_rdata), .tf_rd(tf_rd), .tf_wr(tf_wr), .tf_idx(tf_idx),
    .tf_wdata(tf_wdata), .tf_rdata(tf_rdata), .alt_rd(alt_rd),
    .alt_status(alt_status), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .irq_dma_in(irq_dma_in), .irq_disk_in(irq_disk_in),
    .irq_dma_out(irq_dma_out), .irq_disk_out(irq_disk_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // legality as the requirements state it
  function automatic bit legal(bit w, int unsigned idx, int unsigned sz);
    if (sz == 3) return 0;
    if (idx == 0) return w ? (sz != 0) : 1;
    if (idx >= 1 && idx <= 7) return sz == 0;
    if (idx == 8 || idx == 'h16) return sz == 0;
    if (idx == 'h20 || idx == 'h30) return sz == 2;
    return 0;
  endfunction

  function automatic logic [5:0] exp_strobes(bit v, bit w, int unsigned idx, int unsigned sz);
    logic [5:0] s = '0;
    if (v && legal(w, idx, sz)) begin
      if (idx == 0) s = w ? 6'b010000 : 6'b100000;
      else if (idx <= 7) s = w ? 6'b000100 : 6'b001000;
      else if (idx == 8 || idx == 'h16) s = w ? 6'b000001 : 6'b000010;
    end
    return s;
  endfunction

  function automatic logic [31:0] exp_read(int unsigned idx, int unsigned sz);
    if (!legal(0, idx, sz)) return 32'hFFFF_FFFF;
    if (idx == 0) return sz == 0 ? (df_rdata & 32'hFF) :
                         sz == 1 ? (df_rdata & 32'hFFFF) : df_rdata;
    if (idx <= 7) return {24'd0, tf_rdata};
    if (idx == 8 || idx == 'h16) return {24'd0, alt_status};
    if (idx == 'h20) return m_tim;
    return {m_b31, m_b30, 30'd0};
  endfunction

  task automatic model_edge(bit v, bit w, int unsigned idx, int unsigned sz, logic [31:0] d);
    bit clr;
    clr = v && w && idx == 'h30 && sz == 2 && d[31];
    if (v && w && idx == 'h20 && sz == 2) m_tim = d;
    if (irq_dma_in && !m_p0) m_b31 = 1;
    else if (!irq_dma_in && m_p0) m_b31 = 0;
    else if (clr) m_b31 = 0;
    if (irq_disk_in && !m_p1) m_b30 = 1;
    else if (!irq_disk_in && m_p1) m_b30 = 0;
    m_p0 = irq_dma_in;
    m_p1 = irq_disk_in;
  endtask

  task automatic step(bit v, bit w, logic [11:0] a, logic [1:0] s, logic [31:0] d,
                      string tag);
    int unsigned idx;
    logic [5:0] es;
    logic [31:0] ed;
    idx = int'(a) / 16;
    req_valid = v; req_write = w; req_addr = a; req_size = s; req_wdata = d;
    #1;
    es = exp_strobes(v, w, idx, s);
    chk({df_rd, df_wr, tf_rd, tf_wr, alt_rd, ctl_wr} == es, tag,
        {26'd0, df_rd, df_wr, tf_rd, tf_wr, alt_rd, ctl_wr}, {26'd0, es});
    if (es[5] || es[4]) chk(df_wide == (s == 2), "R3", {31'd0, df_wide}, {31'd0, s == 2});
    if (es[4]) chk(df_wdata == d, "R4", df_wdata, d);
    if (es[3] || es[2]) chk(tf_idx == idx[2:0], "R5", {29'd0, tf_idx}, idx);
    if (es[0]) chk(ctl_wdata == d[7:0], "R6", {24'd0, ctl_wdata}, {24'd0, d[7:0]});
    chk(irq_dma_out == irq_dma_in && irq_disk_out == irq_disk_in, "R11",
        {30'd0, irq_disk_out, irq_dma_out}, {30'd0, irq_disk_in, irq_dma_in});
    ed = w ? 32'hFFFF_FFFF : exp_read(idx, s);
    model_edge(v, w, idx, s, d);
    @(posedge clk); #2;
    chk(rsp_valid == v, "R2", {31'd0, rsp_valid}, {31'd0, v});
    if (v) chk(rsp_rdata == ed, tag, rsp_rdata, ed);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(rsp_valid == 1'b0, "R12", {31'd0, rsp_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // reset state
    step(1, 0, 12'h200, 2, 0, "R12");
    step(1, 0, 12'h300, 2, 0, "R12");
    step(0, 0, 12'h000, 0, 0, "R2");
    // timing register
    step(1, 1, 12'h200, 2, 32'hA5C3_0F12, "R7");
    step(1, 0, 12'h20C, 2, 0, "R1");
    step(1, 1, 12'h200, 1, 32'h1111_2222, "R7");
    step(1, 1, 12'h200, 0, 32'h3333_4444, "R7");
    step(1, 0, 12'h200, 2, 0, "R7");
    step(1, 0, 12'h200, 0, 0, "R7");
    step(1, 0, 12'h200, 3, 0, "R1");
    // data port
    step(1, 0, 12'h000, 0, 0, "R3");
    step(1, 0, 12'h004, 1, 0, "R3");
    step(1, 0, 12'h000, 2, 0, "R3");
    df_rdata = 32'hFEDC_8001;
    step(1, 0, 12'h000, 0, 0, "R3");
    step(1, 0, 12'h000, 1, 0, "R3");
    step(1, 0, 12'h000, 3, 0, "R1");
    step(1, 1, 12'h000, 0, 32'hDEAD_BEEF, "R4");
    step(1, 1, 12'h000, 1, 32'h0000_CAFE, "R4");
    step(1, 1, 12'h000, 2, 32'h0BAD_F00D, "R4");
    // task file
    for (int i = 1; i <= 7; i++) begin
      tf_rdata = 8'(8'h30 + i);
      step(1, 0, 12'(i * 16), 0, 0, "R5");
      step(1, 1, 12'(i * 16 + 3), 0, 32'(i), "R5");
    end
    step(1, 0, 12'h010, 1, 0, "R5");
    step(1, 1, 12'h070, 2, 32'h77, "R5");
    // alternate status / device control
    step(1, 0, 12'h080, 0, 0, "R6");
    alt_status = 8'hD1;
    step(1, 0, 12'h160, 0, 0, "R6");
    step(1, 1, 12'h080, 0, 32'h02, "R6");
    step(1, 1, 12'h16F, 0, 32'h04, "R6");
    step(1, 0, 12'h080, 2, 0, "R6");
    step(1, 1, 12'h160, 1, 32'h06, "R6");
    // unmapped
    step(1, 0, 12'h090, 0, 0, "R1");
    step(1, 0, 12'h400, 2, 0, "R1");
    step(1, 0, 12'hFF0, 2, 0, "R1");
    step(1, 1, 12'h210, 2, 32'h9999_9999, "R12");
    step(1, 1, 12'h150, 0, 32'h55, "R12");
    step(1, 0, 12'h200, 2, 0, "R12");
    // interrupt register
    irq_dma_in = 1;
    step(1, 0, 12'h300, 2, 0, "R9");
    step(1, 0, 12'h300, 2, 0, "R9");
    irq_disk_in = 1;
    step(0, 0, 0, 0, 0, "R9");
    step(1, 0, 12'h300, 2, 0, "R8");
    step(1, 0, 12'h300, 0, 0, "R8");
    step(1, 1, 12'h300, 2, 32'h7FFF_FFFF, "R10");
    step(1, 0, 12'h300, 2, 0, "R10");
    step(1, 1, 12'h300, 2, 32'hFFFF_FFFF, "R10");
    step(1, 0, 12'h300, 2, 0, "R10");
    step(1, 0, 12'h300, 2, 0, "R10");
    irq_dma_in = 0;
    step(1, 0, 12'h300, 2, 0, "R9");
    irq_dma_in = 1;
    step(1, 1, 12'h300, 2, 32'h8000_0000, "R10");
    step(1, 0, 12'h300, 2, 0, "R10");
    irq_disk_in = 0;
    step(1, 0, 12'h300, 2, 0, "R9");
    step(1, 0, 12'h300, 2, 0, "R9");
    irq_dma_in = 0;
    step(1, 0, 12'h300, 2, 0, "R9");
    step(1, 0, 12'h30F, 2, 0, "R8");
    irq_disk_in = 1;
    step(1, 1, 12'h300, 2, 32'h8000_0000, "R10");
    step(1, 0, 12'h300, 2, 0, "R10");
    irq_disk_in = 0;
    step(0, 0, 0, 0, 0, "R2");
    step(1, 0, 12'h300, 2, 0, "R9");
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule